// File: doc/BRIEF.md
# Oscillator Range Change Sequencer

This block decides when a new oscillator frequency range takes effect, and in what order. A two-bit range request arrives with a write strobe. While the low-power bit is set, the block drops the write. When the clock generator is in a loop-engaged mode, an accepted change runs as a sequence. The bus clock stays on the old range while the oscillator for the new range starts up. The bus clock switches when that oscillator reports that it has started. The loop is then reported unlocked for a fixed number of reference ticks. After that, lock returns and the range status shows the new value.

Outside engaged modes no loop has to settle. An accepted change moves the bus clock at once, and the status follows one cycle later. A new accepted request in the middle of a sequence sends the sequence back to its hold phase with the latest value. The oscillators and the mode decoding are outside the block. It sees them only through the engaged input and the started input.

Top module: `dco_range_seq`

## Requirements
- R1: After reset, bus_range, start_range and range_status are 0, and loop_unlocked is 0.
- R2: A write (range_wr high) while low_power is 1 is ignored. start_range, bus_range, range_status and loop_unlocked keep their values, and a later osc_started pulse does not begin a sequence.
- R3: An accepted write while engaged is 1 sets start_range to the requested value on the next clock edge. bus_range and range_status keep their old values, and loop_unlocked stays 0 until osc_started is seen.
- R4: While a sequence waits for the oscillator, an osc_started pulse copies start_range into bus_range and raises loop_unlocked on the next edge.
- R5: loop_unlocked stays high until exactly STARTUP_TICKS cycles with ref_tick high have been seen in the unlocked phase. Cycles without ref_tick do not count.
- R6: On the edge that takes the last tick of the window, loop_unlocked falls and range_status takes the new range. Both change together.
- R7: range_status does not change while a sequence is in progress.
- R8: An accepted write during a sequence restarts it from the hold phase with the latest value. loop_unlocked drops on the next edge, and bus_range keeps the range it had.
- R9: An accepted write while engaged is 0 updates start_range and bus_range on the next edge. range_status updates one edge later, and loop_unlocked stays 0.
- R10: osc_started has no effect when no sequence is waiting for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| range_wr | input | 1 | Write strobe for the range request |
| range_req | input | RANGE_W | Requested range |
| low_power | input | 1 | Low-power bit; blocks range writes when 1 |
| engaged | input | 1 | Loop-engaged mode indication |
| ref_tick | input | 1 | Single-cycle reference clock tick |
| osc_started | input | 1 | Oscillator for the requested range has started |
| start_range | output | RANGE_W | Range the oscillator is asked to run |
| bus_range | output | RANGE_W | Range currently feeding the bus clock |
| loop_unlocked | output | 1 | Loop settling after a range switch |
| range_status | output | RANGE_W | Last range whose change completed |

## Verification
The bench builds the block with STARTUP_TICKS set to 3. At that size each full sequence is short, so the bench can sweep every old/new pair of the four ranges, both engaged and not engaged. It spaces the reference ticks with idle cycles and checks the window edge one tick before the end and at the end. The small window also leaves room to restart a sequence part way through, to write in low-power mode and to send a stray oscillator start.

// File: rtl/dco_range_seq.sv
module dco_range_seq #(
  parameter int RANGE_W = 2,
  parameter int STARTUP_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               range_wr,
  input  logic [RANGE_W-1:0] range_req,
  input  logic               low_power,
  input  logic               engaged,
  input  logic               ref_tick,
  input  logic               osc_started,
  output logic [RANGE_W-1:0] start_range,
  output logic [RANGE_W-1:0] bus_range,
  output logic               loop_unlocked,
  output logic [RANGE_W-1:0] range_status
);
  localparam int CW = $clog2(STARTUP_TICKS) + 1;
  localparam logic [CW-1:0] LAST = CW'(STARTUP_TICKS - 1);

  typedef enum logic [1:0] {IDLE, WAIT_START, UNLOCKED, LOCKED} state_t;

  state_t        state;
  logic [CW-1:0] ticks;
  logic          accept;

  assign accept        = range_wr && !low_power;
  assign loop_unlocked = (state == UNLOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= LOCKED;
      ticks        <= '0;
      start_range  <= '0;
      bus_range    <= '0;
      range_status <= '0;
    end else if (accept) begin
      start_range <= range_req;
      ticks       <= '0;
      if (engaged) begin
        state <= WAIT_START;
      end else begin
        bus_range <= range_req;
        state     <= IDLE;
      end
    end else begin
      case (state)
        IDLE: begin
          range_status <= start_range;
          state        <= LOCKED;
        end
        WAIT_START: if (osc_started) begin
          bus_range <= start_range;
          ticks     <= '0;
          state     <= UNLOCKED;
        end
        UNLOCKED: if (ref_tick) begin
          if (ticks == LAST) begin
            range_status <= start_range;
            state        <= LOCKED;
          end else begin
            ticks <= ticks + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module dco_range_seq_chk #(
  parameter int RANGE_W = 2,
  parameter int STARTUP_TICKS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               range_wr,
  input logic               low_power,
  input logic               ref_tick,
  input logic [RANGE_W-1:0] start_range,
  input logic [RANGE_W-1:0] bus_range,
  input logic               loop_unlocked,
  input logic [RANGE_W-1:0] range_status
);
  localparam int CW = $clog2(STARTUP_TICKS + 1) + 1;
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!loop_unlocked) seen <= '0;
    else if (ref_tick) seen <= seen + 1'b1;
  end

  assert_lp_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (range_wr && low_power) |=> $stable(start_range));

  assert_switch_to_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_unlocked) |-> (bus_range == start_range));

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_unlocked |-> (seen < CW'(STARTUP_TICKS)));

  assert_lock_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(loop_unlocked) && !$past(range_wr && !low_power)) |-> (range_status == start_range));

  assert_status_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_unlocked && $past(loop_unlocked)) |-> $stable(range_status));

  assert_bus_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_unlocked |=> (bus_range == $past(bus_range)));
endmodule

bind dco_range_seq dco_range_seq_chk #(.RANGE_W(RANGE_W), .STARTUP_TICKS(STARTUP_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .range_wr(range_wr), .low_power(low_power), .ref_tick(ref_tick),
  .start_range(start_range), .bus_range(bus_range), .loop_unlocked(loop_unlocked),
  .range_status(range_status)
);

// File: tb/dco_range_seq_test.sv
module dco_range_seq_test;
  localparam int W = 2;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic range_wr = 0, low_power = 0, engaged = 0, ref_tick = 0, osc_started = 0;
  logic [W-1:0] range_req = '0;
  logic [W-1:0] start_range, bus_range, range_status;
  logic loop_unlocked;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dco_range_seq #(.RANGE_W(W), .STARTUP_TICKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .range_wr(range_wr), .range_req(range_req),
    .low_power(low_power), .engaged(engaged), .ref_tick(ref_tick),
    .osc_started(osc_started), .start_range(start_range), .bus_range(bus_range),
    .loop_unlocked(loop_unlocked), .range_status(range_status));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(int r);
    range_req = W'(r); range_wr = 1;
    @(negedge clk);
    range_wr = 0;
  endtask

  task automatic pulse_start();
    osc_started = 1;
    @(negedge clk);
    osc_started = 0;
  endtask

  task automatic tick();
    idle(2);
    ref_tick = 1;
    @(negedge clk);
    ref_tick = 0;
  endtask

  task automatic set_direct(int r);
    engaged = 0;
    write(r);
    idle(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  initial begin
    idle(2);
    chk("R1", "bus_range", bus_range, 0);
    chk("R1", "start_range", start_range, 0);
    chk("R1", "range_status", range_status, 0);
    chk("R1", "loop_unlocked", loop_unlocked, 0);
    rst_n = 1;
    idle(1);

    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        set_direct(o);
        engaged = 1;
        write(n);
        chk("R3", "start_range", start_range, n);
        chk("R3", "bus_range held", bus_range, o);
        chk("R3", "unlocked before start", loop_unlocked, 0);
        idle(3);
        chk("R3", "bus_range still held", bus_range, o);
        chk("R7", "status during hold", range_status, o);
        pulse_start();
        chk("R4", "bus_range switched", bus_range, n);
        chk("R4", "unlocked raised", loop_unlocked, 1);
        for (int t = 0; t < N - 1; t++) tick();
        chk("R5", "unlocked before last tick", loop_unlocked, 1);
        chk("R7", "status during window", range_status, o);
        tick();
        chk("R6", "unlocked after last tick", loop_unlocked, 0);
        chk("R6", "status completed", range_status, n);
      end
    end

    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        set_direct(o);
        write(n);
        chk("R9", "bus_range immediate", bus_range, n);
        chk("R9", "status lags", range_status, o);
        chk("R9", "no unlock", loop_unlocked, 0);
        idle(1);
        chk("R9", "status updated", range_status, n);
      end
    end

    set_direct(1);
    engaged = 1;
    write(2);
    pulse_start();
    tick();
    write(3);
    chk("R8", "unlock dropped on restart", loop_unlocked, 0);
    chk("R8", "start_range latest", start_range, 3);
    chk("R8", "bus_range kept", bus_range, 2);
    chk("R8", "status unchanged", range_status, 1);
    pulse_start();
    chk("R8", "restart unlocked", loop_unlocked, 1);
    for (int t = 0; t < N - 1; t++) tick();
    chk("R8", "full window after restart", loop_unlocked, 1);
    tick();
    chk("R8", "completion after restart", range_status, 3);

    set_direct(2);
    engaged = 1;
    low_power = 1;
    write(0);
    chk("R2", "start_range ignored", start_range, 2);
    chk("R2", "bus_range ignored", bus_range, 2);
    pulse_start();
    chk("R2", "no sequence", loop_unlocked, 0);
    chk("R2", "status ignored", range_status, 2);
    low_power = 0;

    pulse_start();
    idle(1);
    chk("R10", "stray start unlocked", loop_unlocked, 0);
    chk("R10", "stray start bus", bus_range, 2);
    chk("R10", "stray start status", range_status, 2);

    done = 1;
    finish_run();
  end
endmodule